// File: doc/BRIEF.md
# Stop-Grant Clock Control Sequencer

This block lets system hardware put a processor core to sleep in an orderly way. An active-low stop request is handled like an interrupt. The request is taken only at an instruction boundary, and only while no other bus cycle is running. When it is taken, the block starts a special bus cycle that tells the system a stop grant is under way. It keeps that cycle on the bus until the system acknowledges it on either of the two ready inputs. Only then does it remove the core clock enable.

While the core clock is off, a report that the input clock has stopped moves the block into a deeper stop-clock state. When that report clears, the block returns to stop grant. Releasing the stop request from stop grant brings the core clock back. A later assertion of the request starts a new special cycle. All outputs are registered, and the present state is reported on a two-bit port.

Top module: `stopgrant_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in the run state (state code 2'b00) with core_clk_en=1, addr_strobe_n=1 and cyc_drive=0. While idle, addr is 0, byte_en_n is 4'b1111, and mem_io_sel, data_ctrl_sel and write_read_sel are all 0.
- R2: In the run state, the request is recognised only in a cycle where stop_req_n=0, insn_boundary=1 and bus_busy=0 all hold. After that clock edge the state is pending (2'b01) and addr_strobe_n is low for exactly one cycle.
- R3: In every cycle of the pending state, cyc_drive=1, addr=32'h0000_0010, mem_io_sel=0, data_ctrl_sel=0, write_read_sel=1 and byte_en_n=4'b1011.
- R4: The pending state lasts through any number of wait cycles. It ends only when bus_ack_n=0 or burst_ack_n=0 is sampled while pending. After that edge the state is stop grant (2'b10) and the cycle outputs return to their idle values. A request released during pending does not abort the cycle.
- R5: In stop grant and in stop clock, core_clk_en=0. In run and in pending it is 1.
- R6: clk_halted=1 in stop grant moves the block to stop clock (2'b11). clk_halted=0 in stop clock moves it back to stop grant.
- R7: stop_req_n=1 in stop grant returns the block to run with core_clk_en=1. This exit takes priority over clk_halted. In stop clock, releasing the request has no effect.
- R8: bus_ack_n and burst_ack_n are ignored outside the pending state. This includes the cycle in which the request is recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_req_n | input | 1 | Stop request, active low |
| insn_boundary | input | 1 | High at an instruction boundary |
| bus_busy | input | 1 | Another bus cycle is in progress |
| bus_ack_n | input | 1 | Ready acknowledge, active low |
| burst_ack_n | input | 1 | Burst ready acknowledge, active low |
| clk_halted | input | 1 | Input clock reported stopped |
| state | output | 2 | 00 run, 01 pending, 10 stop grant, 11 stop clock |
| core_clk_en | output | 1 | Core clock gate enable |
| addr_strobe_n | output | 1 | Address strobe of the special cycle, active low |
| cyc_drive | output | 1 | Special cycle is on the bus |
| addr | output | ADDR_W | Address of the special cycle |
| mem_io_sel | output | 1 | Memory/IO select of the cycle |
| data_ctrl_sel | output | 1 | Data/control select of the cycle |
| write_read_sel | output | 1 | Write/read select of the cycle |
| byte_en_n | output | BE_W | Byte enables, active low |

## Verification
Every output is registered from the next state. A wrong state therefore shows on the state port, on core_clk_en and on the cycle outputs one clock after the edge that caused it. A stray or missing transition is caught at the next check. A lost acknowledge leaves cyc_drive high with the clock still enabled. An early grant removes core_clk_en while the special cycle is still being presented. A state that wrongly lets the request through or blocks it shows up as a missing or doubled strobe pulse in the cycle after the boundary.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    SG_RUN     = 2'b00,
    SG_PEND    = 2'b01,
    SG_GRANT   = 2'b10,
    SG_CLKSTOP = 2'b11
  } sg_state_e;
endpackage

// File: rtl/sg_ctrl_fsm.sv
module sg_ctrl_fsm
  import sg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      stop_req_n,
  input  logic      insn_boundary,
  input  logic      bus_busy,
  input  logic      ack_any,
  input  logic      clk_halted,
  output sg_state_e state_q,
  output logic      launch,
  output logic      pend_next,
  output logic      core_clk_en_q
);
  sg_state_e state_d;

  always_comb begin
    state_d = state_q;
    launch  = 1'b0;
    case (state_q)
      SG_RUN: begin
        // recognition needs request, boundary and a free bus together
        if (!stop_req_n && insn_boundary && !bus_busy) begin
          launch  = 1'b1;
          state_d = SG_PEND;
        end
      end
      SG_PEND: begin
        if (ack_any) state_d = SG_GRANT;
      end
      SG_GRANT: begin
        if (stop_req_n)      state_d = SG_RUN;      // release wins
        else if (clk_halted) state_d = SG_CLKSTOP;
      end
      SG_CLKSTOP: begin
        if (!clk_halted) state_d = SG_GRANT;
      end
      default: state_d = SG_RUN;
    endcase
  end

  assign pend_next = (state_d == SG_PEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= SG_RUN;
      core_clk_en_q <= 1'b1;
    end else begin
      state_q       <= state_d;
      core_clk_en_q <= (state_d == SG_RUN) || (state_d == SG_PEND);
    end
  end

  assert_pend_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == SG_PEND && $past(state_q) == SG_RUN)
      |-> $past(!stop_req_n && insn_boundary && !bus_busy));

  assert_grant_needs_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == SG_GRANT && $past(state_q) == SG_PEND) |-> $past(ack_any));

  assert_clock_gated_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == SG_GRANT || state_q == SG_CLKSTOP) |-> !core_clk_en_q);

  assert_clkstop_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == SG_CLKSTOP) |-> $past(clk_halted));

  assert_clkstop_holds_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == SG_CLKSTOP && state_q == SG_RUN) |-> 1'b0);
endmodule

// File: rtl/sg_bus_drive.sv
module sg_bus_drive #(
  parameter int              ADDR_W  = 32,
  parameter int              BE_W    = 4,
  parameter logic [ADDR_W-1:0] SG_ADDR = 'h10,
  parameter logic [BE_W-1:0]   SG_BE   = 4'b1011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              pend_next,
  output logic              strobe_n,
  output logic              drive,
  output logic [ADDR_W-1:0] addr,
  output logic              mio,
  output logic              dc,
  output logic              wr,
  output logic [BE_W-1:0]   be_n
);
  localparam logic [BE_W-1:0] BE_IDLE = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_n <= 1'b1;
      drive    <= 1'b0;
      addr     <= '0;
      mio      <= 1'b0;
      dc       <= 1'b0;
      wr       <= 1'b0;
      be_n     <= BE_IDLE;
    end else begin
      strobe_n <= !launch;
      drive    <= pend_next;
      addr     <= pend_next ? SG_ADDR : '0;
      mio      <= 1'b0;
      dc       <= 1'b0;
      wr       <= pend_next;
      be_n     <= pend_next ? SG_BE : BE_IDLE;
    end
  end

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |=> strobe_n);

  assert_strobe_with_drive_R2: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |-> drive);
endmodule

// File: rtl/stopgrant_seq.sv
module stopgrant_seq
  import sg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_req_n,
  input  logic              insn_boundary,
  input  logic              bus_busy,
  input  logic              bus_ack_n,
  input  logic              burst_ack_n,
  input  logic              clk_halted,
  output logic [1:0]        state,
  output logic              core_clk_en,
  output logic              addr_strobe_n,
  output logic              cyc_drive,
  output logic [ADDR_W-1:0] addr,
  output logic              mem_io_sel,
  output logic              data_ctrl_sel,
  output logic              write_read_sel,
  output logic [BE_W-1:0]   byte_en_n
);
  localparam logic [ADDR_W-1:0] GRANT_ADDR = 'h10;
  localparam logic [BE_W-1:0]   GRANT_BE   = 4'b1011;

  sg_state_e st;
  logic      launch, pend_next, ack_any;

  assign ack_any = !bus_ack_n || !burst_ack_n;

  sg_ctrl_fsm u_fsm (
    .clk(clk), .rst(rst), .stop_req_n(stop_req_n),
    .insn_boundary(insn_boundary), .bus_busy(bus_busy),
    .ack_any(ack_any), .clk_halted(clk_halted),
    .state_q(st), .launch(launch), .pend_next(pend_next),
    .core_clk_en_q(core_clk_en)
  );

  sg_bus_drive #(
    .ADDR_W(ADDR_W), .BE_W(BE_W), .SG_ADDR(GRANT_ADDR), .SG_BE(GRANT_BE)
  ) u_bus (
    .clk(clk), .rst(rst), .launch(launch), .pend_next(pend_next),
    .strobe_n(addr_strobe_n), .drive(cyc_drive), .addr(addr),
    .mio(mem_io_sel), .dc(data_ctrl_sel), .wr(write_read_sel), .be_n(byte_en_n)
  );

  assign state = st;

  assert_pend_fields_R3: assert property (@(posedge clk) disable iff (rst)
    (st == SG_PEND) |-> (cyc_drive && addr == GRANT_ADDR && !mem_io_sel &&
                         !data_ctrl_sel && write_read_sel && byte_en_n == GRANT_BE));

  assert_drive_only_pend_R4: assert property (@(posedge clk) disable iff (rst)
    cyc_drive |-> (st == SG_PEND));

  assert_ack_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == SG_RUN && st != SG_RUN) |-> (st == SG_PEND));
endmodule

// File: tb/tb_stopgrant_seq.sv
module tb_stopgrant_seq;
  logic clk = 1'b0;
  logic rst;
  logic stop_req_n, insn_boundary, bus_busy, bus_ack_n, burst_ack_n, clk_halted;
  logic [1:0]  state;
  logic        core_clk_en, addr_strobe_n, cyc_drive;
  logic [31:0] addr;
  logic        mem_io_sel, data_ctrl_sel, write_read_sel;
  logic [3:0]  byte_en_n;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  stopgrant_seq dut (
    .clk(clk), .rst(rst), .stop_req_n(stop_req_n), .insn_boundary(insn_boundary),
    .bus_busy(bus_busy), .bus_ack_n(bus_ack_n), .burst_ack_n(burst_ack_n),
    .clk_halted(clk_halted), .state(state), .core_clk_en(core_clk_en),
    .addr_strobe_n(addr_strobe_n), .cyc_drive(cyc_drive), .addr(addr),
    .mem_io_sel(mem_io_sel), .data_ctrl_sel(data_ctrl_sel),
    .write_read_sel(write_read_sel), .byte_en_n(byte_en_n)
  );

  // vector: {req tag[3:0], inputs[5:0] = sr_n,ib,bb,ack_n,back_n,halt,
  //          expected[4:0] = state[1:0],clk_en,strobe_n,drive}
  localparam int NV = 21;
  localparam logic [14:0] VEC [NV] = '{
    {4'd1, 6'b100110, 5'b00110}, // R1 idle run
    {4'd2, 6'b000110, 5'b00110}, // R2 no boundary
    {4'd2, 6'b011110, 5'b00110}, // R2 bus busy
    {4'd2, 6'b110110, 5'b00110}, // R2 no request
    {4'd8, 6'b110000, 5'b00110}, // R8 acks in run ignored
    {4'd2, 6'b010110, 5'b01101}, // R2 recognised, strobe
    {4'd4, 6'b000110, 5'b01111}, // R4 wait
    {4'd4, 6'b000110, 5'b01111}, // R4 wait
    {4'd4, 6'b000100, 5'b10010}, // R4 burst ack -> grant
    {4'd8, 6'b000000, 5'b10010}, // R8 acks in grant ignored
    {4'd6, 6'b000111, 5'b11010}, // R6 clock stop
    {4'd7, 6'b100111, 5'b11010}, // R7 release ignored in stop clock
    {4'd6, 6'b100110, 5'b10010}, // R6 clock back -> grant
    {4'd7, 6'b100110, 5'b00110}, // R7 release -> run
    {4'd2, 6'b010110, 5'b01101}, // R2 new request
    {4'd4, 6'b000010, 5'b10010}, // R4 ready ack -> grant
    {4'd7, 6'b100111, 5'b00110}, // R7 release wins over halted
    {4'd8, 6'b010010, 5'b01101}, // R8 ack on recognition ignored
    {4'd2, 6'b010110, 5'b01111}, // R2 no second strobe
    {4'd4, 6'b100010, 5'b10010}, // R4 release in pend does not abort
    {4'd7, 6'b100110, 5'b00110}  // R7 back to run
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fields(input string tag, input logic pend);
    chk({tag, " addr"}, 64'(addr), pend ? 64'h10 : 64'h0);
    chk({tag, " be_n"}, 64'(byte_en_n), pend ? 64'hB : 64'hF);
    chk({tag, " ctl"}, 64'({mem_io_sel, data_ctrl_sel, write_read_sel}),
        pend ? 64'h1 : 64'h0);
  endtask

  initial begin : watchdog
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; stop_req_n = 1'b1; insn_boundary = 1'b0; bus_busy = 1'b0;
    bus_ack_n = 1'b1; burst_ack_n = 1'b1; clk_halted = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset state", 64'(state), 64'h0);
    chk("R1 reset outs", 64'({core_clk_en, addr_strobe_n, cyc_drive}), 64'h6);
    fields("R1 idle", 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {stop_req_n, insn_boundary, bus_busy, bus_ack_n, burst_ack_n, clk_halted} =
        VEC[i][10:5];
      @(posedge clk);
      #1;
      chk($sformatf("R%0d vec %0d state", VEC[i][14:11], i), 64'(state), 64'(VEC[i][4:3]));
      chk($sformatf("R%0d vec %0d outs", VEC[i][14:11], i),
          64'({core_clk_en, addr_strobe_n, cyc_drive}), 64'(VEC[i][2:0]));
      fields($sformatf("R3 vec %0d", i), VEC[i][0]);
    end

    // R1: reset in the middle of a pending cycle
    @(negedge clk);
    stop_req_n = 1'b0; insn_boundary = 1'b1; bus_ack_n = 1'b1; burst_ack_n = 1'b1;
    clk_halted = 1'b0;
    @(posedge clk); #1;
    chk("R2 directed pend", 64'(state), 64'h1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset from pend", 64'({state, core_clk_en, addr_strobe_n, cyc_drive}), 64'h06);
    fields("R1 reset idle", 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R2 request held through reset", 64'({state, addr_strobe_n}), 64'h2);

    // R4: long wait then ack, R5 clock gating
    @(negedge clk);
    insn_boundary = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    chk("R4 long wait pend", 64'({state, cyc_drive, core_clk_en}), 64'h7);
    @(negedge clk);
    bus_ack_n = 1'b0;
    @(posedge clk); #1;
    chk("R5 grant gated", 64'({state, core_clk_en, cyc_drive}), 64'h8);
    @(negedge clk);
    bus_ack_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule